// File: doc/BRIEF.md
# Result-Checker Sequencing Controller

This block sequences a small checking pipeline that sits behind a core's retirement stage. Each retired core instruction arrives with the core's claimed values. The pipeline stages compare those values against their own recomputation. The controller decides, cycle by cycle, whether the pipeline runs its stages side by side to verify core values or chains them into a serial path that recomputes one instruction on its own. It also decides when the whole pipeline freezes, when a result may retire to architected state, and when the core must be flushed and restarted.

The controller has three states: idle, checking and serial recovery. Any stage fault flag does not start recovery at once. The instruction is held for one re-check cycle, and recovery begins only if a fault is still flagged in that cycle, so a transient false alarm is dismissed. A watchdog counter is reloaded whenever a result retires. If the counter runs out while the core holds unretired work, the core is restarted and the controller recovers the stuck instruction serially. The watchdog holds its value in cycles with no pending work and during recovery.

Top module: `chk_seq_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it is released, all outputs are low and the controller is idle with the watchdog at its full reload value WDOG_LIMIT.
- R2: In the idle state, commit_en stays low. A cycle with inst_avail high moves the controller to checking at the next edge.
- R3: In checking, commit_en is high in exactly the cycles where inst_avail is high, no hazard bit is set, no stage fault bit is set and no re-check is in progress. Checking returns to idle at the next edge after a cycle with inst_avail low and no re-check in progress.
- R4: In a checking cycle with inst_avail high, no hazard and any stage fault bit set, a re-check starts: stall_all is high in the next cycle. If any fault bit is set in that non-stalled re-check cycle, serial_mode goes high from the following cycle. If no fault bit is set, the alarm is dismissed and the controller stays in checking.
- R5: serial_mode is high exactly while the controller is in the recovery state.
- R6: In recovery, a cycle with rec_done high and no hazard raises commit_en in that cycle. At the next edge the controller leaves recovery for checking if inst_avail is high, and for idle otherwise. core_restart is high for exactly the first cycle after recovery.
- R7: stall_all is high whenever any hazard bit is set or a re-check is in progress. A cycle with any hazard bit set commits nothing, starts no re-check, resolves no re-check and does not finish recovery.
- R8: core_flush is high for exactly the first cycle of each recovery episode.
- R9: The watchdog reloads to WDOG_LIMIT on every commit_en cycle. Outside recovery, it counts down by one in each cycle where core_busy or inst_avail is high. Otherwise it holds its value.
- R10: A counting cycle in which the watchdog is already zero and nothing commits forces recovery from the next edge, with a flush pulse. This takes priority over a re-check outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inst_avail | input | 1 | A retired core instruction is waiting to be checked |
| core_busy | input | 1 | The core holds unretired work (watchdog counting enable) |
| stage_fault | input | NFAULT | Per-stage mismatch flags |
| hazard | input | NHAZ | Cache-miss or resource-conflict stall sources |
| rec_done | input | 1 | Serial recomputation of the current instruction is complete |
| serial_mode | output | 1 | Routing-mux selection: 1 chains the stages serially |
| stall_all | output | 1 | Global freeze of every stage |
| core_flush | output | 1 | One-cycle core flush request |
| core_restart | output | 1 | One-cycle core restart request |
| commit_en | output | 1 | Current result retires to architected state |

## Verification
commit_en and stall_all are combinational in the current cycle's inputs and state, so the bench compares them in the same cycle the stimulus is applied. serial_mode, core_flush and core_restart change one edge after the deciding cycle. A confirmed fault shows on serial_mode two edges after it is first flagged. A watchdog reload followed by WDOG_LIMIT+1 counting cycles without a commit shows as recovery at the next edge. The bench applies inputs just after the falling edge, compares 1 ns later against a cycle model advanced at each rising edge, and so samples every result in the cycle where it is due.

// File: rtl/chk_seq_ctrl.sv
module chk_seq_ctrl #(
  parameter int NFAULT     = 4,
  parameter int NHAZ       = 2,
  parameter int WDOG_LIMIT = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inst_avail,
  input  logic              core_busy,
  input  logic [NFAULT-1:0] stage_fault,
  input  logic [NHAZ-1:0]   hazard,
  input  logic              rec_done,
  output logic              serial_mode,
  output logic              stall_all,
  output logic              core_flush,
  output logic              core_restart,
  output logic              commit_en
);
  localparam int CW = $clog2(WDOG_LIMIT + 1);
  localparam logic [CW-1:0] RELOAD = CW'(WDOG_LIMIT);

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_EXEC} st_t;

  st_t           st, st_n;
  logic          recheck, recheck_n;
  logic [CW-1:0] wd_cnt;
  logic          flush_q, restart_q;

  wire haz      = |hazard;
  wire flt      = |stage_fault;
  wire counting = (st != S_EXEC) && (core_busy || inst_avail);
  wire wd_zero  = (wd_cnt == '0);

  assign commit_en = (st == S_CHECK && inst_avail && !haz && !recheck && !flt) ||
                     (st == S_EXEC && rec_done && !haz);

  wire wd_fire = counting && wd_zero && !commit_en;

  assign stall_all    = haz || recheck;
  assign serial_mode  = (st == S_EXEC);
  assign core_flush   = flush_q;
  assign core_restart = restart_q;

  always_comb begin
    st_n = st;
    recheck_n = 1'b0;
    case (st)
      S_IDLE: begin
        if (wd_fire) st_n = S_EXEC;
        else if (inst_avail) st_n = S_CHECK;
      end
      S_CHECK: begin
        if (wd_fire) st_n = S_EXEC;
        else if (recheck) begin
          if (haz) recheck_n = 1'b1;
          else if (flt) st_n = S_EXEC;
        end else if (!inst_avail) st_n = S_IDLE;
        else if (!haz && flt) recheck_n = 1'b1;
      end
      S_EXEC: begin
        if (rec_done && !haz) st_n = inst_avail ? S_CHECK : S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      recheck   <= 1'b0;
      wd_cnt    <= RELOAD;
      flush_q   <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      st        <= st_n;
      recheck   <= recheck_n;
      flush_q   <= (st_n == S_EXEC) && (st != S_EXEC);
      restart_q <= (st == S_EXEC) && (st_n != S_EXEC);
      if (commit_en) wd_cnt <= RELOAD;
      else if (counting && !wd_zero) wd_cnt <= wd_cnt - 1'b1;
    end
  end
endmodule

module chk_seq_ctrl_props #(
  parameter int NHAZ = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NHAZ-1:0] hazard,
  input logic            rec_done,
  input logic            serial_mode,
  input logic            stall_all,
  input logic            core_flush,
  input logic            core_restart,
  input logic            commit_en
);
  assert_flush_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    core_flush |=> !core_flush);
  assert_flush_in_recovery_R8: assert property (@(posedge clk) disable iff (!rst_n)
    core_flush |-> serial_mode);
  assert_entry_flushes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(serial_mode) |-> core_flush);
  assert_restart_after_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    core_restart |-> (!serial_mode && $past(serial_mode)));
  assert_exit_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(serial_mode) |-> core_restart);
  assert_hazard_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|hazard) |-> (stall_all && !commit_en));
  assert_recovery_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (serial_mode && !rec_done) |=> serial_mode);
endmodule

bind chk_seq_ctrl chk_seq_ctrl_props #(.NHAZ(NHAZ)) u_props (
  .clk(clk), .rst_n(rst_n), .hazard(hazard), .rec_done(rec_done),
  .serial_mode(serial_mode), .stall_all(stall_all), .core_flush(core_flush),
  .core_restart(core_restart), .commit_en(commit_en)
);

// File: tb/chk_seq_ctrl_bench.sv
module chk_seq_ctrl_bench;
  localparam int NF = 4, NH = 2, WD = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic inst_avail = 0, core_busy = 0, rec_done = 0;
  logic [NF-1:0] stage_fault = '0;
  logic [NH-1:0] hazard = '0;
  logic serial_mode, stall_all, core_flush, core_restart, commit_en;

  int n_cmp = 0, n_bad = 0;
  int m_st = 0, m_cnt = WD;
  bit m_rc = 0, m_fl = 0, m_rs = 0;

  always #10 clk = ~clk;

  chk_seq_ctrl #(.NFAULT(NF), .NHAZ(NH), .WDOG_LIMIT(WD)) u_chk_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .inst_avail(inst_avail), .core_busy(core_busy),
    .stage_fault(stage_fault), .hazard(hazard), .rec_done(rec_done),
    .serial_mode(serial_mode), .stall_all(stall_all), .core_flush(core_flush),
    .core_restart(core_restart), .commit_en(commit_en));

  task automatic cmp(string tag, string sig, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, sig, act, exp, $time);
    end
  endtask

  function automatic bit exp_commit(bit ia, bit fl, bit hz, bit rd);
    return (m_st == 1 && ia && !hz && !m_rc && !fl) || (m_st == 2 && rd && !hz);
  endfunction

  task automatic step(string tag, bit ia, bit cb, logic [NF-1:0] f, logic [NH-1:0] h, bit rd);
    bit hz, fl, cm, cnt_on, fire, rc_n;
    int st_n;
    @(negedge clk);
    inst_avail = ia; core_busy = cb; stage_fault = f; hazard = h; rec_done = rd;
    #1;
    hz = |h; fl = |f;
    cm = exp_commit(ia, fl, hz, rd);
    cmp(tag, "serial_mode", serial_mode, m_st == 2);
    cmp(tag, "stall_all", stall_all, hz || m_rc);
    cmp(tag, "core_flush", core_flush, m_fl);
    cmp(tag, "core_restart", core_restart, m_rs);
    cmp(tag, "commit_en", commit_en, cm);
    cnt_on = (m_st != 2) && (cb || ia);
    fire = cnt_on && m_cnt == 0 && !cm;
    st_n = m_st; rc_n = 0;
    if (m_st == 0) begin
      if (fire) st_n = 2; else if (ia) st_n = 1;
    end else if (m_st == 1) begin
      if (fire) st_n = 2;
      else if (m_rc) begin
        if (hz) rc_n = 1; else if (fl) st_n = 2;
      end else if (!ia) st_n = 0;
      else if (!hz && fl) rc_n = 1;
    end else if (rd && !hz) st_n = ia ? 1 : 0;
    @(posedge clk);
    m_fl = (st_n == 2) && (m_st != 2);
    m_rs = (m_st == 2) && (st_n != 2);
    if (cm) m_cnt = WD; else if (cnt_on && m_cnt != 0) m_cnt--;
    m_st = st_n; m_rc = rc_n;
  endtask

  initial begin : watchdog
    #3000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(posedge clk);
    #1;
    cmp("R1", "serial_mode", serial_mode, 0);
    cmp("R1", "stall_all", stall_all, 0);
    cmp("R1", "core_flush", core_flush, 0);
    cmp("R1", "core_restart", core_restart, 0);
    cmp("R1", "commit_en", commit_en, 0);
    @(negedge clk); rst_n = 1;
    // idle start and plain checking
    step("R2", 0, 0, '0, '0, 0);
    step("R2", 1, 1, '0, '0, 0);
    step("R3", 1, 1, '0, '0, 0);
    step("R3", 1, 1, '0, '0, 0);
    step("R3", 0, 0, '0, '0, 0);
    step("R2", 0, 0, '0, '0, 0);
    // dismissed false alarm
    step("R4", 1, 1, '0, '0, 0);
    step("R4", 1, 1, 4'b0100, '0, 0);
    step("R4", 1, 1, '0, '0, 0);
    step("R4", 1, 1, '0, '0, 0);
    // confirmed fault, hazard during re-check, recovery
    step("R4", 1, 1, 4'b0001, '0, 0);
    step("R7", 1, 1, 4'b0001, 2'b10, 0);
    step("R4", 1, 1, 4'b1000, '0, 0);
    step("R8", 1, 1, '0, '0, 0);
    step("R7", 1, 1, '0, 2'b01, 1);
    step("R6", 0, 1, '0, '0, 1);
    step("R6", 0, 0, '0, '0, 0);
    // watchdog: one commit, then stuck core
    step("R9", 1, 1, '0, '0, 0);
    step("R9", 1, 1, '0, '0, 0);
    for (int i = 0; i < WD + 3; i++) step("R10", 0, 1, '0, '0, 0);
    step("R10", 1, 1, '0, '0, 1);
    // watchdog kept alive by commits
    for (int i = 0; i < 3 * WD; i++) step("R9", 1, 1, '0, (i % 3 == 1) ? 2'b01 : 2'b00, 0);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      step("R5", ($urandom % 10) < 7, ($urandom % 10) < 8,
           (($urandom % 10) == 0) ? NF'($urandom) : '0,
           (($urandom % 7) == 0) ? NH'($urandom) : '0,
           ($urandom % 5) < 2);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule